// File: doc/BRIEF.md
# Time-Base, Watchdog and Tone Generator

This block turns a 32 kHz tick into the slow timing outputs of a display controller. A single shared counter first divides the tick by 256 and then continues as a binary chain, so the time-base output can be taken from one of eight taps. The slowest tap gives 1 Hz and the fastest gives 128 Hz.

A watchdog counts four periods of the selected tap and then raises a sticky time-out flag. If interrupts are enabled, the same time-out also pulls an active-low request line low and holds it there. A separate small divider on the same tick produces a complementary buzzer pair at 4 kHz (tick/8) or 2 kHz (tick/16).

All control comes from one-clock command pulses issued by a command decoder. The pulses cover system on/off, timer on/off/clear, watchdog on/off/clear, interrupt on/off, rate load and tone select/off. When both the on and off pulse of the same feature arrive in one cycle, the off pulse wins. A clear also wins over counting in the same cycle.

Top module: `tbase_wdt_tone`

## Requirements
- R1: After synchronous reset: `timebase_o`=0, `wdt_flag_o`=0, `irq_n_o`=1 and both buzzer outputs are 0. The system is enabled, the timer, watchdog, interrupt and tone are disabled, and the rate code is 0.
- R2: While the timer is enabled, `timebase_o` (registered) equals bit (14 - code) of the shared tick counter, with `PRE_BITS`=8. This gives a square wave of 2^(15-code) ticks per period: code 0 is 1 Hz and code 7 is 128 Hz. A rate load takes effect on the next clock.
- R3: While the timer is disabled, `timebase_o` is 0. A timer-clear pulse resets the whole shared counter to zero.
- R4: With the watchdog enabled, every wrap of the counter below the selected tap advances a 2-bit stage. The wrap whose stage is 3 sets `wdt_flag_o`, so the time-out comes after four selected periods (4 s at code 0, 1/32 s at code 7). The flag then stays set.
- R5: A watchdog-clear pulse resets the stage and the flag, and releases `irq_n_o` to 1.
- R6: A time-out while interrupts are enabled drives `irq_n_o` to 0. It stays 0 until a watchdog-clear or interrupt-disable pulse. A time-out while interrupts are disabled leaves `irq_n_o` at 1.
- R7: The timer, watchdog and interrupt enables are independent. For example, disabling the timer does not stop the watchdog from timing out.
- R8: Tone mode 4 kHz gives `buzz_p_o` a 50% square wave with a period of 8 ticks. Tone mode 2 kHz gives a period of 16 ticks. `buzz_n_o` is the complement of `buzz_p_o` while a tone is on.
- R9: After a tone-off pulse, both buzzer outputs are 0.
- R10: While the system is disabled, the shared counter and the tone divider freeze and both buzzer outputs are 0. After the system is enabled again, counting resumes from the frozen value.
- R11: While the watchdog is disabled, its stage does not advance and a cleared flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock pulse per 32 kHz period |
| sys_en_i | input | 1 | System enable pulse |
| sys_dis_i | input | 1 | System disable pulse |
| tmr_en_i | input | 1 | Time-base output enable pulse |
| tmr_dis_i | input | 1 | Time-base output disable pulse |
| tmr_clr_i | input | 1 | Shared counter clear pulse |
| wdt_en_i | input | 1 | Watchdog enable pulse |
| wdt_dis_i | input | 1 | Watchdog disable pulse |
| wdt_clr_i | input | 1 | Watchdog stage/flag clear pulse |
| irq_en_i | input | 1 | Interrupt enable pulse |
| irq_dis_i | input | 1 | Interrupt disable pulse (also releases request) |
| rate_set_i | input | 1 | Load `rate_code_i` |
| rate_code_i | input | RATE_W | Rate selection code |
| tone_hi_i | input | 1 | Select 4 kHz tone |
| tone_lo_i | input | 1 | Select 2 kHz tone |
| tone_off_i | input | 1 | Stop tone |
| timebase_o | output | 1 | Selected time-base clock |
| wdt_flag_o | output | 1 | Sticky watchdog time-out flag |
| irq_n_o | output | 1 | Active-low interrupt request |
| buzz_p_o | output | 1 | Buzzer drive, true phase |
| buzz_n_o | output | 1 | Buzzer drive, inverted phase |

## Verification
The assertions assume that the command inputs are single-cycle pulses sampled on `clk`. They also assume that `tick_i` needs no pulse-width limit, because every counter advances only on a clock where the tick is high. The stimulus issues each command for exactly one clock. It drives `tick_i` either high on every clock or from a pseudo-random pattern, so the bench covers both back-to-back and sparse ticks. The bench builds the block with a three-bit prescaler, so watchdog time-outs at both the fastest and the slowest codes fit into a short run.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [1:0] {
    TONE_NONE = 2'd0,
    TONE_HI   = 2'd1,
    TONE_LO   = 2'd2
  } tone_mode_t;
endpackage

// File: rtl/tbase_divchain.sv
module tbase_divchain #(
  parameter int PRE_BITS = 8,
  parameter int RATE_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              clr_i,
  input  logic [RATE_W-1:0] sel_i,
  output logic              tap_o,
  output logic              wrap_o
);
  localparam int NRATES = 1 << RATE_W;
  localparam int CW     = PRE_BITS + NRATES - 1;
  localparam int IDX_W  = $clog2(CW);

  logic [CW-1:0]    cnt_q;
  logic [IDX_W-1:0] tap_idx;
  logic             low_full;

  assign tap_idx = IDX_W'(CW - 1) - IDX_W'(sel_i);
  assign tap_o   = cnt_q[tap_idx];

  always_comb begin
    low_full = 1'b1;
    for (int i = 0; i < CW; i++) begin
      if (i <= int'(tap_idx)) low_full = low_full & cnt_q[i];
    end
  end

  assign wrap_o = adv_i & ~clr_i & low_full;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !clr_i) |=> $stable(cnt_q)) else $error("counter moved without tick");
  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0)) else $error("counter not cleared");
endmodule

// File: rtl/tbase_wdt.sv
module tbase_wdt #(
  parameter int STAGE_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic step_i,
  input  logic clr_i,
  input  logic irq_on_i,
  input  logic irq_clr_i,
  output logic flag_o,
  output logic pend_o
);
  localparam logic [STAGE_W-1:0] LAST = {STAGE_W{1'b1}};

  logic [STAGE_W-1:0] stage_q;
  logic               flag_q;
  logic               pend_q;
  logic               expire;

  assign expire = run_i & step_i & (stage_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      stage_q <= '0;
      flag_q  <= 1'b0;
    end else if (run_i && step_i) begin
      stage_q <= stage_q + 1'b1;
      if (stage_q == LAST) flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i || irq_clr_i) pend_q <= 1'b0;
    else if (expire && irq_on_i)   pend_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign pend_o = pend_q;

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q) else $error("flag dropped");
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_i && !irq_clr_i) |=> pend_q) else $error("irq released early");
  assert_stage_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!(run_i && step_i) && !clr_i) |=> $stable(stage_q)) else $error("stage moved");
  assert_clr_release_R5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!flag_q && !pend_q)) else $error("clear ignored");
endmodule

// File: rtl/tbase_tone.sv
module tbase_tone
  import tbase_pkg::*;
#(
  parameter int HI_LOG2 = 3,
  parameter int LO_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv_i,
  input  logic       sys_on_i,
  input  tone_mode_t mode_i,
  output logic       p_o,
  output logic       n_o
);
  localparam int TW = (HI_LOG2 > LO_LOG2) ? HI_LOG2 : LO_LOG2;

  logic [TW-1:0] tcnt_q;
  logic          phase;
  logic          on;
  logic          p_q, n_q;

  assign phase = (mode_i == TONE_HI) ? tcnt_q[HI_LOG2-1] : tcnt_q[LO_LOG2-1];
  assign on    = (mode_i != TONE_NONE) & sys_on_i;

  always_ff @(posedge clk) begin
    if (rst)        tcnt_q <= '0;
    else if (adv_i) tcnt_q <= tcnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      p_q <= on & phase;
      n_q <= on & ~phase;
    end
  end

  assign p_o = p_q;
  assign n_o = n_q;

  assert_tone_pair_R8: assert property (@(posedge clk) disable iff (rst)
    on |=> (p_q != n_q)) else $error("buzzer pair not complementary");
endmodule

// File: rtl/tbase_wdt_tone.sv
module tbase_wdt_tone
  import tbase_pkg::*;
#(
  parameter int PRE_BITS = 8,
  parameter int RATE_W   = 3,
  parameter int STAGE_W  = 2,
  parameter int HI_LOG2  = 3,
  parameter int LO_LOG2  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              sys_en_i,
  input  logic              sys_dis_i,
  input  logic              tmr_en_i,
  input  logic              tmr_dis_i,
  input  logic              tmr_clr_i,
  input  logic              wdt_en_i,
  input  logic              wdt_dis_i,
  input  logic              wdt_clr_i,
  input  logic              irq_en_i,
  input  logic              irq_dis_i,
  input  logic              rate_set_i,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic              tone_hi_i,
  input  logic              tone_lo_i,
  input  logic              tone_off_i,
  output logic              timebase_o,
  output logic              wdt_flag_o,
  output logic              irq_n_o,
  output logic              buzz_p_o,
  output logic              buzz_n_o
);
  logic              sys_on, tmr_on, wdt_on, irq_on;
  logic [RATE_W-1:0] rate_q;
  tone_mode_t        tone_q;
  logic              adv, tap, wrap, pend, tb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_on <= 1'b1;
      tmr_on <= 1'b0;
      wdt_on <= 1'b0;
      irq_on <= 1'b0;
      rate_q <= '0;
      tone_q <= TONE_NONE;
    end else begin
      if (sys_dis_i)     sys_on <= 1'b0;
      else if (sys_en_i) sys_on <= 1'b1;
      if (tmr_dis_i)     tmr_on <= 1'b0;
      else if (tmr_en_i) tmr_on <= 1'b1;
      if (wdt_dis_i)     wdt_on <= 1'b0;
      else if (wdt_en_i) wdt_on <= 1'b1;
      if (irq_dis_i)     irq_on <= 1'b0;
      else if (irq_en_i) irq_on <= 1'b1;
      if (rate_set_i)    rate_q <= rate_code_i;
      if (tone_off_i)     tone_q <= TONE_NONE;
      else if (tone_hi_i) tone_q <= TONE_HI;
      else if (tone_lo_i) tone_q <= TONE_LO;
    end
  end

  assign adv = tick_i & sys_on;

  tbase_divchain #(.PRE_BITS(PRE_BITS), .RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .adv_i(adv), .clr_i(tmr_clr_i),
    .sel_i(rate_q), .tap_o(tap), .wrap_o(wrap)
  );

  tbase_wdt #(.STAGE_W(STAGE_W)) u_wdt (
    .clk(clk), .rst(rst), .run_i(wdt_on), .step_i(wrap), .clr_i(wdt_clr_i),
    .irq_on_i(irq_on), .irq_clr_i(irq_dis_i), .flag_o(wdt_flag_o), .pend_o(pend)
  );

  tbase_tone #(.HI_LOG2(HI_LOG2), .LO_LOG2(LO_LOG2)) u_tone (
    .clk(clk), .rst(rst), .adv_i(adv), .sys_on_i(sys_on), .mode_i(tone_q),
    .p_o(buzz_p_o), .n_o(buzz_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) tb_q <= 1'b0;
    else     tb_q <= tmr_on & tap;
  end

  assign timebase_o = tb_q;
  assign irq_n_o    = ~pend;

  assert_tb_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !tmr_on |=> !timebase_o) else $error("time base not gated");
  assert_tone_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (tone_q == TONE_NONE) |=> (!buzz_p_o && !buzz_n_o)) else $error("tone while off");
  assert_sys_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !sys_on |=> (!buzz_p_o && !buzz_n_o)) else $error("tone while system off");
  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> wdt_flag_o) else $error("irq without time-out");
endmodule

// File: tb/tbase_wdt_tone_tb_top.sv
module tbase_wdt_tone_tb_top;
  localparam int PRE_BITS = 3;
  localparam int CW = PRE_BITS + 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b1;
  logic sys_en_i = 0, sys_dis_i = 0, tmr_en_i = 0, tmr_dis_i = 0, tmr_clr_i = 0;
  logic wdt_en_i = 0, wdt_dis_i = 0, wdt_clr_i = 0, irq_en_i = 0, irq_dis_i = 0;
  logic rate_set_i = 0, tone_hi_i = 0, tone_lo_i = 0, tone_off_i = 0;
  logic [2:0] rate_code_i = 3'd0;
  logic timebase_o, wdt_flag_o, irq_n_o, buzz_p_o, buzz_n_o;

  always #2 clk = ~clk;

  tbase_wdt_tone #(.PRE_BITS(PRE_BITS)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .sys_en_i(sys_en_i), .sys_dis_i(sys_dis_i),
    .tmr_en_i(tmr_en_i), .tmr_dis_i(tmr_dis_i), .tmr_clr_i(tmr_clr_i),
    .wdt_en_i(wdt_en_i), .wdt_dis_i(wdt_dis_i), .wdt_clr_i(wdt_clr_i),
    .irq_en_i(irq_en_i), .irq_dis_i(irq_dis_i),
    .rate_set_i(rate_set_i), .rate_code_i(rate_code_i),
    .tone_hi_i(tone_hi_i), .tone_lo_i(tone_lo_i), .tone_off_i(tone_off_i),
    .timebase_o(timebase_o), .wdt_flag_o(wdt_flag_o), .irq_n_o(irq_n_o),
    .buzz_p_o(buzz_p_o), .buzz_n_o(buzz_n_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  int m_sys, m_tmr, m_wdt, m_irq, m_rate, m_tone;
  int m_cnt, m_tcnt, m_stage, m_flag, m_pend;
  int e_tb, e_p, e_n;

  always @(posedge clk) begin
    int idx, mask, ph, on, adv, wrap;
    started = 1;
    if (rst) begin
      m_sys = 1; m_tmr = 0; m_wdt = 0; m_irq = 0; m_rate = 0; m_tone = 0;
      m_cnt = 0; m_tcnt = 0; m_stage = 0; m_flag = 0; m_pend = 0;
      e_tb = 0; e_p = 0; e_n = 0;
    end else begin
      idx  = CW - 1 - m_rate;
      mask = (1 << (idx + 1)) - 1;
      adv  = (tick_i && m_sys != 0) ? 1 : 0;
      e_tb = (m_tmr != 0) ? ((m_cnt >> idx) & 1) : 0;
      ph   = (m_tone == 1) ? ((m_tcnt >> 2) & 1) : ((m_tcnt >> 3) & 1);
      on   = (m_tone != 0 && m_sys != 0) ? 1 : 0;
      e_p  = on & ph;
      e_n  = on & (1 - ph);
      wrap = (adv != 0 && !tmr_clr_i && (m_cnt & mask) == mask) ? 1 : 0;
      if (wdt_clr_i) begin
        m_stage = 0; m_flag = 0; m_pend = 0;
      end else begin
        if (m_wdt != 0 && wrap != 0) begin
          if (m_stage == 3) begin
            m_flag = 1;
            if (m_irq != 0) m_pend = 1;
          end
          m_stage = (m_stage + 1) % 4;
        end
        if (irq_dis_i) m_pend = 0;
      end
      if (tmr_clr_i) m_cnt = 0;
      else if (adv != 0) m_cnt = (m_cnt + 1) % (1 << CW);
      if (adv != 0) m_tcnt = (m_tcnt + 1) % 16;
      if (sys_dis_i) m_sys = 0; else if (sys_en_i) m_sys = 1;
      if (tmr_dis_i) m_tmr = 0; else if (tmr_en_i) m_tmr = 1;
      if (wdt_dis_i) m_wdt = 0; else if (wdt_en_i) m_wdt = 1;
      if (irq_dis_i) m_irq = 0; else if (irq_en_i) m_irq = 1;
      if (rate_set_i) m_rate = int'(rate_code_i);
      if (tone_off_i) m_tone = 0; else if (tone_hi_i) m_tone = 1; else if (tone_lo_i) m_tone = 2;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      cmp("R2 timebase", int'(timebase_o), e_tb);
      cmp("R4 wdt flag", int'(wdt_flag_o), m_flag);
      cmp("R6 irq_n", int'(irq_n_o), 1 - m_pend);
      cmp("R8 buzz_p", int'(buzz_p_o), e_p);
      cmp("R8 buzz_n", int'(buzz_n_o), e_n);
    end
  end

  // tick source: every clock, or pseudo-random when gap_mode is set
  bit gap_mode = 0;
  logic [15:0] lf = 16'hACE1;
  always @(negedge clk) begin
    #1;
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    tick_i <= gap_mode ? lf[0] : 1'b1;
  end

  localparam int C_SYS_EN = 0, C_SYS_DIS = 1, C_TMR_EN = 2, C_TMR_DIS = 3, C_TMR_CLR = 4;
  localparam int C_WDT_EN = 5, C_WDT_DIS = 6, C_WDT_CLR = 7, C_IRQ_EN = 8, C_IRQ_DIS = 9;
  localparam int C_RATE = 10, C_HI = 11, C_LO = 12, C_OFF = 13;

  task automatic drive(input int id, input logic v);
    case (id)
      C_SYS_EN:  sys_en_i = v;
      C_SYS_DIS: sys_dis_i = v;
      C_TMR_EN:  tmr_en_i = v;
      C_TMR_DIS: tmr_dis_i = v;
      C_TMR_CLR: tmr_clr_i = v;
      C_WDT_EN:  wdt_en_i = v;
      C_WDT_DIS: wdt_dis_i = v;
      C_WDT_CLR: wdt_clr_i = v;
      C_IRQ_EN:  irq_en_i = v;
      C_IRQ_DIS: irq_dis_i = v;
      C_RATE:    rate_set_i = v;
      C_HI:      tone_hi_i = v;
      C_LO:      tone_lo_i = v;
      default:   tone_off_i = v;
    endcase
  endtask

  task automatic cmd(input int id, input int code = 0);
    @(negedge clk); #1;
    rate_code_i = 3'(code);
    drive(id, 1'b1);
    @(negedge clk); #1;
    drive(id, 1'b0);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int dummy0();
    return 0;
  endfunction

  task automatic count_rises(input int which, input int intervals, output int rises);
    logic prev, cur;
    rises = 0;
    @(negedge clk);
    prev = (which == 0) ? timebase_o : buzz_p_o;
    for (int k = 0; k < intervals; k++) begin
      @(negedge clk);
      cur = (which == 0) ? timebase_o : buzz_p_o;
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  initial begin
    int r;
    logic frozen;
    wait_n(3); #1;
    rst = 0;
    wait_n(2);
    // R1 reset state
    cmp("R1 timebase", int'(timebase_o), 0);
    cmp("R1 flag", int'(wdt_flag_o), 0);
    cmp("R1 irq_n", int'(irq_n_o), 1);
    cmp("R1 buzz", int'({buzz_p_o, buzz_n_o}), 0);

    // R2: code 7 -> 8 ticks per period
    cmd(C_TMR_EN); cmd(C_RATE, 7); wait_n(3);
    count_rises(0, 64, r);
    cmp("R2 rises at code 7", r, 8);
    cmd(C_RATE, 5); wait_n(3);
    count_rises(0, 128, r);
    cmp("R2 rises at code 5", r, 4);

    // R3 gating and clear
    cmd(C_TMR_DIS); wait_n(2);
    cmp("R3 timebase off", int'(timebase_o), 0);
    cmd(C_TMR_EN); cmd(C_TMR_CLR); wait_n(40);

    // sparse ticks with timer and tone: checked by the reference model
    gap_mode = 1;
    cmd(C_RATE, 6); cmd(C_HI); wait_n(300);
    cmd(C_LO); wait_n(300);
    gap_mode = 0;
    cmd(C_OFF); wait_n(3);

    // R4/R6 watchdog time-out at code 7 (32 ticks)
    cmd(C_RATE, 7); cmd(C_IRQ_EN); cmd(C_WDT_CLR); cmd(C_WDT_EN);
    wait_n(45);
    cmp("R4 flag after time-out", int'(wdt_flag_o), 1);
    cmp("R6 irq_n low", int'(irq_n_o), 0);
    cmd(C_IRQ_DIS); wait_n(2);
    cmp("R6 irq released by disable", int'(irq_n_o), 1);
    cmp("R4 flag sticky", int'(wdt_flag_o), 1);
    wait_n(45);
    cmp("R6 no irq while disabled", int'(irq_n_o), 1);
    cmd(C_IRQ_EN); wait_n(45);
    cmp("R6 irq low again", int'(irq_n_o), 0);
    cmd(C_WDT_CLR); wait_n(2);
    cmp("R5 flag cleared", int'(wdt_flag_o), 0);
    cmp("R5 irq released", int'(irq_n_o), 1);

    // R7 watchdog runs with timer disabled
    cmd(C_TMR_DIS); wait_n(45);
    cmp("R7 flag with timer off", int'(wdt_flag_o), 1);

    // R11 watchdog disabled
    cmd(C_WDT_DIS); cmd(C_WDT_CLR); wait_n(100);
    cmp("R11 flag stays clear", int'(wdt_flag_o), 0);
    cmp("R11 irq stays high", int'(irq_n_o), 1);

    // R8 tone periods
    cmd(C_HI); wait_n(3);
    count_rises(1, 64, r);
    cmp("R8 4k rises", r, 8);
    cmp("R8 pair complementary", int'(buzz_p_o ^ buzz_n_o), 1);
    cmd(C_LO); wait_n(3);
    count_rises(1, 64, r);
    cmp("R8 2k rises", r, 4);
    cmd(C_OFF); wait_n(2);
    cmp("R9 buzz off", int'({buzz_p_o, buzz_n_o}), 0);

    // R10 system disable freezes
    cmd(C_TMR_EN); cmd(C_HI); cmd(C_RATE, 7); wait_n(5);
    cmd(C_SYS_DIS); wait_n(2);
    frozen = timebase_o;
    cmp("R10 buzz low", int'({buzz_p_o, buzz_n_o}), 0);
    wait_n(30);
    cmp("R10 timebase frozen", int'(timebase_o), int'(frozen));
    cmd(C_SYS_EN); wait_n(20);

    // R4 slowest code: 4 * 1024 ticks
    cmd(C_OFF); cmd(C_RATE, 0); cmd(C_TMR_CLR); cmd(C_WDT_CLR); cmd(C_WDT_EN);
    wait_n(4000);
    cmp("R4 no early time-out at code 0", int'(wdt_flag_o), 0);
    wait_n(200);
    cmp("R4 time-out at code 0", int'(wdt_flag_o), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule